// File: doc/BRIEF.md
# Delay Sweep Measurement Controller

This controller measures the propagation delay of an unknown path by sweeping the code of a programmable delay channel. A launch edge drives two delay channels at the same moment. The reference channel is held at its minimum setting and feeds the device under measurement, whose output reaches the data input of an external sampling flip-flop. The second channel clocks that flip-flop, and its delay code comes from this block. After each trial the controller reads the flip-flop. A 1 means the swept delay is too long, so the code must come down. A 0 means the swept delay is too short, so the code must go up.

The search is a successive approximation over the code, one trial per bit, starting at the most significant bit. A confirmation phase then repeats the trial a fixed number of times at the final code. A sample that flips between 1 and 0 during these trials shows that the code sits on the edge of the unknown delay. If no flip is seen and the code is pinned at either end of its range, an out-of-range flag is raised. Before each trigger, the controller holds the code steady for a number of settle cycles set by software, so the analog delay line can settle.

The state machine has five states. IDLE waits for start and moves to SETTLE when start is seen. SETTLE counts the settle cycles and moves to FIRE when the count expires. FIRE sends the trigger and always moves to SAMPLE. SAMPLE reads the sample bit. It moves to DONE after the last confirmation trial and back to SETTLE in every other case. DONE raises done for one cycle and returns to IDLE.

Top module: `dsw_sweep_ctrl`

## Requirements
- R1: After reset, every output is 0: code, trigger, busy, done, reference-minimum, result, toggle and range flags.
- R2: A start pulse in IDLE begins a measurement. Busy and the reference-minimum output stay high from then until done. A start pulse seen while busy has no effect on the trigger count or on the result.
- R3: Each measurement issues exactly CODE_W + CONFIRM_N triggers. Each trigger is a single-cycle pulse.
- R4: The first trial code has only bit CODE_W-1 set (512 at the default width). After trial k, which tests bit CODE_W-k, a sample of 1 clears that bit and a sample of 0 keeps it. Every trial except the last search trial also sets the next lower bit for the following trial. All confirmation trials use the final search code, and that code is the reported result.
- R5: With settle value S latched at start, consecutive triggers of one measurement are exactly S+3 cycles apart. The code output is unchanged for at least S+1 cycles before each trigger and during the trigger cycle.
- R6: The sample input is read only in the cycle that follows a trigger. Its value in any other cycle has no effect.
- R7: If the sample is 1 exactly when the code is greater than D, for an integer D in 0..2^CODE_W-1, the result equals D.
- R8: If each trial compares the code against D plus a jitter of -1, 0 or +1 (with a random outcome on a tie), the result lies within 2 of D.
- R9: The toggle output is 1 if and only if the confirmation trials returned both a 0 and a 1.
- R10: The range flag is 1 if and only if the result is 0 or 2^CODE_W-1 and the toggle output is 0.
- R11: Done is high for exactly one cycle, and busy falls in the next cycle. The result, toggle and range outputs are valid in the done cycle and hold until the next start. The code output then holds the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a measurement (accepted only in IDLE) |
| settle_i | input | SETTLE_W | Settle cycles before each trigger, latched at start |
| sample_i | input | 1 | Sampling flip-flop output: 1 means the swept delay is too long |
| code_o | output | CODE_W | Delay code for the swept channel |
| ref_min_o | output | 1 | Forces the reference channel to minimum delay |
| trigger_o | output | 1 | Launch pulse shared by both channels |
| busy_o | output | 1 | A measurement is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | CODE_W | Measured code |
| toggle_o | output | 1 | Sample flipped during confirmation |
| range_err_o | output | 1 | Result pinned at a range end without a flip |

## Verification
The bench builds the block with its defaults: a 10-bit code, 8 confirmation trials and a 4-bit settle field. This lets it use settle values from 0 up to 15, which covers the back-to-back case with no settle cycles. The 10-bit code allows delays to be placed exactly on code 0 and code 1023, as well as beyond either end. Eight confirmation trials are enough for a responder that alternates on the edge to produce a clear flip. A model of the unknown path answers every trigger in one of three ways: as a sharp threshold, as an alternating edge, or with ±1 jitter. The bench predicts each trial code and the final flags from the samples it has returned.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_FIRE,
        ST_SAMPLE,
        ST_DONE
    } dsw_state_e;

    typedef enum logic {
        PH_SEARCH,
        PH_CONFIRM
    } dsw_phase_e;

endpackage

// File: rtl/dsw_settle_timer.sv
// Counts settle cycles while the controller waits in SETTLE; expires after limit+1 cycles.
module dsw_settle_timer #(
    parameter int SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic [SETTLE_W-1:0] limit_i,
    output logic                expired_o
);

    logic [SETTLE_W-1:0] cnt_q;

    assign expired_o = (cnt_q == limit_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (!expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/dsw_sar_step.sv
// One successive-approximation step: resolve the tested bit, arm the next lower one.
module dsw_sar_step #(
    parameter int CODE_W = 10,
    parameter int IDX_W  = 4
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              too_long_i,
    output logic [CODE_W-1:0] next_code_o,
    output logic              at_lsb_o
);

    assign at_lsb_o = (idx_i == '0);

    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
        always_comb begin
            if (int'(idx_i) == b) begin
                next_code_o[b] = code_i[b] & ~too_long_i;
            end else if (int'(idx_i) == b + 1) begin
                next_code_o[b] = 1'b1;
            end else begin
                next_code_o[b] = code_i[b];
            end
        end
    end

endmodule

// File: rtl/dsw_confirm_tally.sv
// Counts confirmation trials and remembers which sample values appeared.
module dsw_confirm_tally #(
    parameter int CONFIRM_N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic en_i,
    input  logic sample_i,
    output logic last_o,
    output logic saw_one_o,
    output logic saw_zero_o
);

    localparam int CNT_W = $clog2(CONFIRM_N + 1);

    logic [CNT_W-1:0] count_q;
    logic             one_q;
    logic             zero_q;

    assign last_o     = en_i && (count_q == CNT_W'(CONFIRM_N - 1));
    assign saw_one_o  = one_q  | (en_i &  sample_i);
    assign saw_zero_o = zero_q | (en_i & ~sample_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            one_q   <= 1'b0;
            zero_q  <= 1'b0;
        end else if (clear_i) begin
            count_q <= '0;
            one_q   <= 1'b0;
            zero_q  <= 1'b0;
        end else if (en_i) begin
            count_q <= count_q + 1'b1;
            one_q   <= saw_one_o;
            zero_q  <= saw_zero_o;
        end
    end

endmodule

// File: rtl/dsw_sweep_ctrl.sv
module dsw_sweep_ctrl
    import dsw_pkg::*;
#(
    parameter int CODE_W    = 10,
    parameter int CONFIRM_N = 8,
    parameter int SETTLE_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic                sample_i,
    output logic [CODE_W-1:0]   code_o,
    output logic                ref_min_o,
    output logic                trigger_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [CODE_W-1:0]   result_o,
    output logic                toggle_o,
    output logic                range_err_o
);

    localparam int              IDX_W      = $clog2(CODE_W);
    localparam logic [CODE_W-1:0] CODE_FIRST = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] CODE_TOP   = {CODE_W{1'b1}};

    dsw_state_e          state_q, state_d;
    dsw_phase_e          phase_q;
    logic [CODE_W-1:0]   code_q;
    logic [IDX_W-1:0]    idx_q;
    logic [SETTLE_W-1:0] settle_q;
    logic [CODE_W-1:0]   result_q;
    logic                toggle_q;
    logic                range_q;

    logic                accept;
    logic                settled;
    logic [CODE_W-1:0]   next_code;
    logic                at_lsb;
    logic                confirm_en;
    logic                confirm_last;
    logic                saw_one;
    logic                saw_zero;

    assign accept     = (state_q == ST_IDLE) && start_i;
    assign confirm_en = (state_q == ST_SAMPLE) && (phase_q == PH_CONFIRM);

    dsw_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (state_q != ST_SETTLE),
        .limit_i  (settle_q),
        .expired_o(settled)
    );

    dsw_sar_step #(.CODE_W(CODE_W), .IDX_W(IDX_W)) u_step (
        .code_i     (code_q),
        .idx_i      (idx_q),
        .too_long_i (sample_i),
        .next_code_o(next_code),
        .at_lsb_o   (at_lsb)
    );

    dsw_confirm_tally #(.CONFIRM_N(CONFIRM_N)) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (accept),
        .en_i      (confirm_en),
        .sample_i  (sample_i),
        .last_o    (confirm_last),
        .saw_one_o (saw_one),
        .saw_zero_o(saw_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_SETTLE;
            ST_SETTLE: if (settled) state_d = ST_FIRE;
            ST_FIRE:   state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = confirm_last ? ST_DONE : ST_SETTLE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Search datapath and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= PH_SEARCH;
            code_q   <= '0;
            idx_q    <= '0;
            settle_q <= '0;
            result_q <= '0;
            toggle_q <= 1'b0;
            range_q  <= 1'b0;
        end else if (accept) begin
            phase_q  <= PH_SEARCH;
            code_q   <= CODE_FIRST;
            idx_q    <= IDX_W'(CODE_W - 1);
            settle_q <= settle_i;
        end else if (state_q == ST_SAMPLE) begin
            if (phase_q == PH_SEARCH) begin
                code_q <= next_code;
                if (at_lsb) begin
                    phase_q <= PH_CONFIRM;
                end else begin
                    idx_q <= idx_q - 1'b1;
                end
            end else if (confirm_last) begin
                result_q <= code_q;
                toggle_q <= saw_one && saw_zero;
                range_q  <= ((code_q == '0) || (code_q == CODE_TOP))
                            && !(saw_one && saw_zero);
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        busy_o    = 1'b1;
        trigger_o = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy_o    = 1'b0;
            ST_SETTLE: busy_o    = 1'b1;
            ST_FIRE:   trigger_o = 1'b1;
            ST_SAMPLE: busy_o    = 1'b1;
            ST_DONE:   done_o    = 1'b1;
            default:   busy_o    = 1'b0;
        endcase
    end

    assign ref_min_o   = busy_o;
    assign code_o      = code_q;
    assign result_o    = result_q;
    assign toggle_o    = toggle_q;
    assign range_err_o = range_q;

endmodule

// File: rtl/dsw_checker.sv
module dsw_checker #(
    parameter int CODE_W   = 10,
    parameter int SETTLE_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic [SETTLE_W-1:0] settle_i,
    input logic                trigger_o,
    input logic                done_o,
    input logic                busy_o,
    input logic [CODE_W-1:0]   code_o,
    input logic [CODE_W-1:0]   result_o,
    input logic                toggle_o,
    input logic                range_err_o
);

    localparam int HOLD_W = SETTLE_W + 1;

    logic [SETTLE_W-1:0] settle_lat;
    logic [CODE_W-1:0]   prev_code;
    logic [HOLD_W-1:0]   hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_lat <= '0;
            prev_code  <= '0;
            hold_q     <= '0;
        end else begin
            if (start_i && !busy_o) settle_lat <= settle_i;
            prev_code <= code_o;
            if (code_o != prev_code) hold_q <= '0;
            else if (hold_q != '1)   hold_q <= hold_q + 1'b1;
        end
    end

    a_r3_trigger_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        trigger_o |=> !trigger_o);

    a_r5_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
        trigger_o |-> $stable(code_o));

    a_r5_settle_window: assert property (@(posedge clk) disable iff (!rst_n)
        trigger_o |-> (hold_q >= {1'b0, settle_lat}));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(result_o));

    a_r10_range_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && range_err_o) |->
            (((result_o == '0) || (result_o == {CODE_W{1'b1}})) && !toggle_o));

    a_r2_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

endmodule

bind dsw_sweep_ctrl dsw_checker #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) u_dsw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .settle_i   (settle_i),
    .trigger_o  (trigger_o),
    .done_o     (done_o),
    .busy_o     (busy_o),
    .code_o     (code_o),
    .result_o   (result_o),
    .toggle_o   (toggle_o),
    .range_err_o(range_err_o)
);

// File: tb/dsw_sweep_ctrl_bench.sv
`timescale 1ns/1ps
module dsw_sweep_ctrl_bench;

    localparam int W  = 10;
    localparam int NC = 8;
    localparam int SW = 4;
    localparam int TOP = (1 << W) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [SW-1:0] settle_i = '0;
    logic          sample_i = 1'b0;
    logic [W-1:0]  code_o;
    logic          ref_min_o, trigger_o, busy_o, done_o, toggle_o, range_err_o;
    logic [W-1:0]  result_o;

    always #2.5 clk = ~clk;

    dsw_sweep_ctrl #(.CODE_W(W), .CONFIRM_N(NC), .SETTLE_W(SW)) u_dsw_sweep_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_i(settle_i),
        .sample_i(sample_i), .code_o(code_o), .ref_min_o(ref_min_o),
        .trigger_o(trigger_o), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o), .toggle_o(toggle_o), .range_err_o(range_err_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Path model: 0 sharp threshold, 1 alternating on the edge, 2 jitter of +-1
    int mode, d_val, cur_settle;
    bit alt_q;

    // Per-measurement observations
    int cyc, last_trig, trig_cnt, first_code, exp_code, gap_bad, seq_bad, ref_bad;
    bit pend, saw1, saw0;

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit path_model(int c);
        bit s;
        int e;
        if (mode == 0) begin
            s = (c > d_val);
        end else if (mode == 1) begin
            if (c == d_val) begin s = alt_q; alt_q = ~alt_q; end
            else s = (c > d_val);
        end else begin
            e = d_val + int'($urandom_range(2)) - 1;
            if (c > e) s = 1'b1;
            else if (c < e) s = 1'b0;
            else s = 1'(($urandom) & 1);
        end
        return s;
    endfunction

    // Trigger monitor and sample driver
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (trigger_o) begin
                bit s;
                int c;
                int k;
                trig_cnt++;
                k = trig_cnt;
                c = int'(code_o);
                if (!ref_min_o) ref_bad++;
                if (k == 1) first_code = c;
                else begin
                    if (cyc - last_trig != cur_settle + 3) gap_bad++;
                    if (c != exp_code) seq_bad++;
                end
                last_trig = cyc;
                s = path_model(c);
                sample_i <= s;
                pend = 1;
                if (k < W) exp_code = (s ? (c & ~(1 << (W - k))) : c) | (1 << (W - k - 1));
                else if (k == W) exp_code = s ? (c & ~1) : c;
                else begin
                    exp_code = c;
                    if (s) saw1 = 1; else saw0 = 1;
                end
            end else if (pend) begin
                pend = 0;
            end else begin
                sample_i <= 1'(($urandom) & 1); // R6: noise outside the read cycle
            end
        end
    end

    task automatic measure(int m, int d, int s, bit extra_start, int exp_res, int exp_tog, int exp_err);
        int exp_final;
        int e_tog, e_err;
        mode = m; d_val = d; cur_settle = s; alt_q = 0;
        trig_cnt = 0; gap_bad = 0; seq_bad = 0; ref_bad = 0; saw1 = 0; saw0 = 0;
        @(negedge clk);
        settle_i <= SW'(s);
        start_i  <= 1'b1;
        @(negedge clk);
        start_i  <= 1'b0;
        check(busy_o && ref_min_o, "R2 busy after start", int'(busy_o), 1);
        if (extra_start) begin
            repeat (7) @(negedge clk);
            start_i <= 1'b1;
            settle_i <= SW'(15 - s);
            @(negedge clk);
            start_i <= 1'b0;
            repeat (3 * s + 11) @(negedge clk);
            start_i <= 1'b1;
            @(negedge clk);
            start_i <= 1'b0;
        end
        while (!done_o) @(negedge clk);
        exp_final = exp_code;
        e_tog = (saw1 && saw0) ? 1 : 0;
        e_err = ((exp_final == 0 || exp_final == TOP) && e_tog == 0) ? 1 : 0;
        check(trig_cnt == W + NC, "R3 trigger count", trig_cnt, W + NC);
        check(first_code == (1 << (W - 1)), "R4 first trial code", first_code, 1 << (W - 1));
        check(seq_bad == 0, "R4 trial code sequence", seq_bad, 0);
        check(int'(result_o) == exp_final, "R4 result equals final trial code", int'(result_o), exp_final);
        check(gap_bad == 0, "R5 trigger spacing", gap_bad, 0);
        check(ref_bad == 0, "R2 reference minimum at trigger", ref_bad, 0);
        check(int'(toggle_o) == e_tog, "R9 toggle flag", int'(toggle_o), e_tog);
        check(int'(range_err_o) == e_err, "R10 range flag", int'(range_err_o), e_err);
        check(code_o == result_o, "R11 code holds result", int'(code_o), int'(result_o));
        if (exp_res >= 0) check(int'(result_o) == exp_res, "R7 R6 exact result", int'(result_o), exp_res);
        else begin
            int dd;
            dd = int'(result_o) - d;
            check(dd >= -2 && dd <= 2, "R8 result near delay", int'(result_o), d);
        end
        if (exp_tog >= 0) check(int'(toggle_o) == exp_tog, "R9 directed toggle", int'(toggle_o), exp_tog);
        if (exp_err >= 0) check(int'(range_err_o) == exp_err, "R10 directed range", int'(range_err_o), exp_err);
        @(negedge clk);
        check(!done_o && !busy_o, "R11 done single cycle", int'(done_o) + int'(busy_o), 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(code_o == '0 && !trigger_o && !busy_o && !done_o && !ref_min_o,
              "R1 reset outputs", int'(code_o), 0);
        check(result_o == '0 && !toggle_o && !range_err_o, "R1 reset results", int'(result_o), 0);

        measure(0, 600, 2, 0, 600, 0, 0);
        measure(0, 0, 0, 0, 0, 0, 1);
        measure(0, TOP, 5, 0, TOP, 0, 1);
        measure(0, -5, 1, 0, 0, 0, 1);
        measure(0, 2000, 3, 0, TOP, 0, 1);
        measure(1, 0, 1, 0, 0, 1, 0);
        measure(1, 377, 3, 0, 377, 1, 0);
        measure(1, TOP, 0, 0, TOP, 1, 0);
        measure(0, 222, 4, 1, 222, 0, 0);   // R2: extra starts while busy
        measure(0, 1, 15, 0, 1, 0, 0);

        for (int i = 0; i < 14; i++) begin
            measure(2, 4 + int'($urandom_range(TOP - 8)), int'($urandom_range(15)), 0, -1, -1, -1);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule